// File: doc/BRIEF.md
# Character I/O Flag and Interrupt Enable Unit

This unit sits beside the accumulator of a small word-oriented processor and looks after its character I/O. It holds one received byte and one byte waiting to be sent. Next to them it keeps a receive-full flag, a transmit-ready flag and the interrupt enable bit. The device side raises a strobe when a new byte has arrived and another when the pending output byte has been taken. From these two flags the unit forms an interrupt request. The same flags answer the processor's skip-on-flag tests.

While the execute strobe for an I/O instruction is high, the unit decodes six one-hot control bits, instruction bits 11 down to 6. Each bit selects one action: take input, send output, skip if input is ready, skip if output is ready, enable interrupts or disable interrupts. The block gives the sequencer a skip request and a sequence-clear pulse. It tells the accumulator when to capture the received byte. When the interrupt entry sequence finishes, the sequencer pulses an input that turns interrupts off.

Top module: `io_flag_unit`

## Requirements
- R1: After reset, rx_data_o and tx_data_o are 0, rx_full_o is 0, tx_ready_o is 1 and int_en_o is 0.
- R2: A cycle with rx_strobe high loads rx_byte into rx_data_o and sets rx_full_o at the next clock edge. This holds even when an input instruction executes in the same cycle.
- R3: The take-input instruction is io_exec high with io_bits[5] high (instruction bit 11). It drives rx_take_o high in that same cycle while rx_data_o still shows the held byte. At the next edge it clears rx_full_o, unless rx_strobe is also high.
- R4: The send-output instruction is io_exec high with io_bits[4] high (instruction bit 10). At the next edge it loads acc_lo into tx_data_o and clears tx_ready_o. It takes priority over tx_taken in the same cycle.
- R5: tx_taken high, with no send-output instruction in the same cycle, sets tx_ready_o at the next edge.
- R6: skip_req is high in the same cycle exactly when io_exec is high and at least one of these holds: io_bits[3] (bit 9) is high and rx_full_o is 1, or io_bits[2] (bit 8) is high and tx_ready_o is 1.
- R7: io_bits[1] (bit 7) under io_exec sets int_en_o at the next edge. io_bits[0] (bit 6) under io_exec clears it. When both bits are set, the clear wins.
- R8: intr_entry_done clears int_en_o at the next edge and overrides an enable in the same cycle.
- R9: intr_req equals int_en_o AND (rx_full_o OR tx_ready_o).
- R10: seq_clear equals io_exec. While io_exec is low, io_bits has no effect on any output or held state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_exec | input | 1 | I/O instruction execute strobe |
| io_bits | input | 6 | Instruction bits 11..6 (index 5 = bit 11) |
| acc_lo | input | DW | Low byte of the accumulator |
| rx_strobe | input | 1 | Device delivered a new byte |
| rx_byte | input | DW | Byte from the input device |
| tx_taken | input | 1 | Device consumed the output byte |
| intr_entry_done | input | 1 | Interrupt entry sequence finished |
| rx_data_o | output | DW | Held received byte |
| rx_take_o | output | 1 | Accumulator should capture rx_data_o now |
| tx_data_o | output | DW | Byte offered to the output device |
| rx_full_o | output | 1 | Receive-full flag |
| tx_ready_o | output | 1 | Transmit-ready flag |
| int_en_o | output | 1 | Interrupt enable |
| skip_req | output | 1 | Request to advance the program counter once more |
| intr_req | output | 1 | Interrupt request |
| seq_clear | output | 1 | Clear the sequence counter |

## Verification
The bench targets collisions: a byte arriving while an input instruction clears the flag, and the device taking the output byte while a new byte is written. It also covers enable and disable set together, and an enable in the same cycle as interrupt-entry completion. If a design ordered these wrongly, it would lose a received byte, report a fresh output byte as already sent, or leave interrupts enabled on entry. The bench also drives idle instruction bits with io_exec low to catch decoding that is not gated by the strobe. It checks that skips are answered from the flag values before the edge, not after.

// File: rtl/io_flag_unit.sv
module io_flag_unit #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_exec,
  input  logic [5:0]    io_bits,
  input  logic [DW-1:0] acc_lo,
  input  logic          rx_strobe,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_taken,
  input  logic          intr_entry_done,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_take_o,
  output logic [DW-1:0] tx_data_o,
  output logic          rx_full_o,
  output logic          tx_ready_o,
  output logic          int_en_o,
  output logic          skip_req,
  output logic          intr_req,
  output logic          seq_clear
);

  logic do_inp, do_out, do_ski, do_sko, do_ion, do_iof;

  assign do_inp = io_exec & io_bits[5];
  assign do_out = io_exec & io_bits[4];
  assign do_ski = io_exec & io_bits[3];
  assign do_sko = io_exec & io_bits[2];
  assign do_ion = io_exec & io_bits[1];
  assign do_iof = io_exec & io_bits[0];

  assign rx_take_o = do_inp;
  assign seq_clear = io_exec;
  assign skip_req  = (do_ski & rx_full_o) | (do_sko & tx_ready_o);
  assign intr_req  = int_en_o & (rx_full_o | tx_ready_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data_o  <= '0;
      rx_full_o  <= 1'b0;
    end else if (rx_strobe) begin
      rx_data_o  <= rx_byte;
      rx_full_o  <= 1'b1;
    end else if (do_inp) begin
      rx_full_o  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_data_o  <= '0;
      tx_ready_o <= 1'b1;
    end else if (do_out) begin
      tx_data_o  <= acc_lo;
      tx_ready_o <= 1'b0;
    end else if (tx_taken) begin
      tx_ready_o <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         int_en_o <= 1'b0;
    else if (intr_entry_done || do_iof) int_en_o <= 1'b0;
    else if (do_ion)                    int_en_o <= 1'b1;
  end

  AST_RX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |=> rx_full_o && rx_data_o == $past(rx_byte)); // R2
  AST_INP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_bits[5] && !rx_strobe) |=> !rx_full_o); // R3
  AST_OUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_bits[4]) |=> !tx_ready_o && tx_data_o == $past(acc_lo)); // R4
  AST_TX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_taken && !(io_exec && io_bits[4])) |=> tx_ready_o); // R5
  AST_ION_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (io_exec && io_bits[1] && !io_bits[0] && !intr_entry_done) |=> int_en_o); // R7
  AST_ENTRY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    intr_entry_done |=> !int_en_o); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_exec && !intr_entry_done) |=> $stable(int_en_o)); // R10

endmodule

// File: tb/tb_io_flag_unit.sv
module tb_io_flag_unit;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          io_exec, rx_strobe, tx_taken, intr_entry_done;
  logic [5:0]    io_bits;
  logic [DW-1:0] acc_lo, rx_byte;
  logic [DW-1:0] rx_data_o, tx_data_o;
  logic          rx_take_o, rx_full_o, tx_ready_o, int_en_o, skip_req, intr_req, seq_clear;

  io_flag_unit #(.DW(DW)) dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] m_rx, m_tx;
  logic          m_rxf, m_txf, m_ie;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_skip();
    return io_exec & ((io_bits[3] & m_rxf) | (io_bits[2] & m_txf));
  endfunction

  task automatic check_state();
    chk("R2 rx_data", rx_data_o, m_rx);
    chk("R2/R3 rx_full", rx_full_o, m_rxf);
    chk("R4 tx_data", tx_data_o, m_tx);
    chk("R4/R5 tx_ready", tx_ready_o, m_txf);
    chk("R7/R8 int_en", int_en_o, m_ie);
  endtask

  task automatic step(input logic ex, input logic [5:0] b, input logic [DW-1:0] acc,
                      input logic rs, input logic [DW-1:0] rb, input logic tt, input logic ed);
    logic inp, out, ion, iof;
    io_exec = ex; io_bits = b; acc_lo = acc;
    rx_strobe = rs; rx_byte = rb; tx_taken = tt; intr_entry_done = ed;
    #2;
    chk("R6 skip_req", skip_req, exp_skip());
    chk("R9 intr_req", intr_req, m_ie & (m_rxf | m_txf));
    chk("R10 seq_clear", seq_clear, ex);
    chk("R3 rx_take", rx_take_o, ex & b[5]);
    inp = ex & b[5]; out = ex & b[4]; ion = ex & b[1]; iof = ex & b[0];
    @(posedge clk);
    if (rs) begin m_rx = rb; m_rxf = 1'b1; end
    else if (inp) m_rxf = 1'b0;
    if (out) begin m_tx = acc; m_txf = 1'b0; end
    else if (tt) m_txf = 1'b1;
    if (ed || iof) m_ie = 1'b0;
    else if (ion) m_ie = 1'b1;
    @(negedge clk);
    check_state();
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; io_exec = 0; io_bits = 0; acc_lo = 0;
    rx_strobe = 0; rx_byte = 0; tx_taken = 0; intr_entry_done = 0;
    repeat (3) @(negedge clk);
    m_rx = 0; m_tx = 0; m_rxf = 0; m_txf = 1; m_ie = 0;
    check_state(); // R1
    rst_n = 1'b1;

    step(1, 6'b000100, 8'h00, 0, 8'h00, 0, 0);   // R6 skip on tx ready
    step(0, 6'b000000, 8'h00, 1, 8'hA5, 0, 0);   // R2 byte arrives
    step(1, 6'b001000, 8'h00, 0, 8'h00, 0, 0);   // R6 skip on rx full
    step(1, 6'b100000, 8'h00, 1, 8'h3C, 0, 0);   // R3 vs R2 collision
    step(1, 6'b100000, 8'h00, 0, 8'h00, 0, 0);   // R3 clear
    step(1, 6'b010000, 8'h5A, 0, 8'h00, 1, 0);   // R4 beats R5
    step(0, 6'b000000, 8'h00, 0, 8'h00, 1, 0);   // R5
    step(1, 6'b000011, 8'h00, 0, 8'h00, 0, 0);   // R7 both: clear wins
    step(1, 6'b000010, 8'h00, 0, 8'h00, 0, 0);   // R7 enable
    step(1, 6'b000010, 8'h00, 0, 8'h00, 0, 1);   // R8 entry beats enable
    step(1, 6'b000010, 8'h00, 0, 8'h00, 0, 0);   // R7
    step(0, 6'b111111, 8'hFF, 0, 8'h00, 0, 0);   // R10 bits ignored
    step(0, 6'b110001, 8'h77, 0, 8'h00, 0, 0);   // R10

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] b;
      b = 6'b1 << ($urandom % 6);
      if (($urandom % 8) == 0) b = $urandom;
      step(($urandom % 2) == 1, b, $urandom, ($urandom % 4) == 0, $urandom,
           ($urandom % 4) == 0, ($urandom % 16) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule